// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery Controller

This block performs direct (wired) interrupt delivery for a small group of harts. For every hart it holds a delivery enable, a force bit and a priority threshold. It continuously picks the most urgent source that is enabled, pending and aimed at that hart, and from that choice it drives the hart's external interrupt line. The per-source state lives outside the block and arrives as vectors: pending, enable, trigger mode, input level, target hart index and target priority. Sources are numbered from 1, and source 0 does not exist.

Software reaches each hart through a 32-byte register window. Hart `h` owns addresses `h*32` to `h*32+31`. Reading the claim register is the acknowledge. In the same cycle as that read, the block emits one-cycle strobes that clear the claimed source's pending bit, and sets that bit again when a level-triggered source is still asserting. The owner of the pending vector applies `next = (pending & ~pend_clr) | pend_set` at the clock edge that ends the read.

Reads and writes use separate address and strobe channels, so a read and a write can fall in the same cycle. Read data is combinational and valid in the cycle of `rd_en`. The block has no state machine. Its sequential state is three small registers per hart, held in one per-hart control submodule. The selection is a combinational priority scan, and the claim side effects are pure decode that happens in the cycle of the strobe.

Top module: `hart_irq_dispatch`

## Requirements
- R1: After reset every hart's delivery enable, force and threshold read 0, the top-interrupt register reads 0 and every interrupt line is low.
- R2: Window offsets are 0x00 delivery enable, 0x04 force, 0x08 threshold, 0x18 top interrupt and 0x1C claim. Delivery enable and force store only write-data bit 0. The threshold stores the low PRIO_W bits. Writes to 0x18 and 0x1C change nothing, and reads of any other offset return 0.
- R3: A source qualifies for hart h when it is pending, it is enabled and its target hart field equals h. The winner is the qualifying source with the numerically lowest priority. On a tie, the lowest source number wins.
- R4: A target priority field of 0 is ranked, and reported, as priority 1.
- R5: With a nonzero threshold T, sources whose priority is T or higher are excluded. A threshold of 0 excludes nothing.
- R6: The top-interrupt value carries the winning source number in bits 25:16 and its priority, zero-extended, in bits 7:0. All other bits are 0. The value is 0 when no source qualifies.
- R7: A hart's interrupt line equals domain_en AND delivery enable AND (force OR a qualifying source exists), with no register delay.
- R8: A claim read returns the current top-interrupt value in that cycle and raises pend_clr for exactly the winning source, for that cycle only. A read of the top-interrupt offset has no side effect.
- R9: During a claim, pend_set is raised for the winner when its mode code is 6 (level-high) and its input is 1, or when its mode code is 7 (level-low) and its input is 0. Any other mode code gives no pend_set.
- R10: A claim read that finds no qualifying source returns 0 and clears that hart's force bit at the next edge. A write to the force register in the same cycle takes precedence over that clear.
- R11: A claim read in the same cycle as a threshold write to the same hart selects its winner with the threshold held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| domain_en | input | 1 | Domain-wide interrupt enable |
| src_pending | input | NSRC | Pending bit per source, bit i is source i |
| src_enable | input | NSRC | Enable bit per source |
| src_mode | input | 3*NSRC | Trigger-mode code per source (6 level-high, 7 level-low) |
| src_level | input | NSRC | Current input level per source |
| src_hart | input | HART_W*NSRC | Target hart index per source |
| src_prio | input | PRIO_W*NSRC | Target priority per source |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address (hart*32 + offset) |
| rd_data | output | 32 | Read data, valid in the cycle of rd_en |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address (hart*32 + offset) |
| wr_data | input | 32 | Write data |
| hart_irq | output | NUM_HARTS | External interrupt line per hart |
| pend_clr | output | NSRC | One-cycle pending-clear strobe per source |
| pend_set | output | NSRC | One-cycle pending-set strobe per source |

## Verification
The claim read can coincide with a register write, and the two same-cycle collisions that matter are covered here. The bench issues an empty claim together with a write of 1 to the same hart's force register, and expects force to read back 1 afterwards. It also issues a winning claim together with a threshold write that would exclude the winner, and expects the claim to return the winner while the new threshold is stored. Apart from these, a swept set of random source configurations is checked against an arithmetic model of the selection and line equations for both harts. Directed claims cover each trigger mode and input level.

// File: rtl/hid_pkg.sv
package hid_pkg;
    localparam logic [4:0] OFF_DELIV  = 5'h00;
    localparam logic [4:0] OFF_FORCE  = 5'h04;
    localparam logic [4:0] OFF_THRESH = 5'h08;
    localparam logic [4:0] OFF_TOP    = 5'h18;
    localparam logic [4:0] OFF_CLAIM  = 5'h1C;

    localparam logic [2:0] MODE_LVL_HI = 3'd6;
    localparam logic [2:0] MODE_LVL_LO = 3'd7;

    localparam int ID_W = 10;
endpackage

// File: rtl/hid_select.sv
module hid_select #(
    parameter int NSRC   = 8,
    parameter int HART_W = 2,
    parameter int PRIO_W = 3,
    parameter int HART   = 0
) (
    input  logic [NSRC:1]             pend,
    input  logic [NSRC:1]             en,
    input  logic [NSRC*HART_W-1:0]    tgt_hart,
    input  logic [NSRC*PRIO_W-1:0]    tgt_prio,
    input  logic [PRIO_W-1:0]         thresh,
    output logic                      found,
    output logic [hid_pkg::ID_W-1:0]  best_id,
    output logic [PRIO_W-1:0]         best_prio
);
    always_comb begin
        logic [PRIO_W-1:0] p;
        logic              ok;
        p         = '0;
        ok        = 1'b0;
        found     = 1'b0;
        best_id   = '0;
        best_prio = '0;
        for (int i = 1; i <= NSRC; i++) begin
            p = tgt_prio[(i-1)*PRIO_W +: PRIO_W];
            if (p == '0) p = PRIO_W'(1);
            ok = pend[i] && en[i] &&
                 (tgt_hart[(i-1)*HART_W +: HART_W] == HART_W'(HART)) &&
                 ((thresh == '0) || (p < thresh));
            // strict compare keeps the lowest source number on ties
            if (ok && (!found || (p < best_prio))) begin
                found     = 1'b1;
                best_id   = hid_pkg::ID_W'(i);
                best_prio = p;
            end
        end
    end
endmodule

// File: rtl/hid_hart_ctl.sv
module hid_hart_ctl #(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_deliv,
    input  logic              wr_force,
    input  logic              wr_thresh,
    input  logic              wbit,
    input  logic [PRIO_W-1:0] wthr,
    input  logic              empty_claim,
    output logic              deliv_q,
    output logic              force_q,
    output logic [PRIO_W-1:0] thresh_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deliv_q  <= 1'b0;
            force_q  <= 1'b0;
            thresh_q <= '0;
        end else begin
            if (wr_deliv)  deliv_q  <= wbit;
            if (wr_thresh) thresh_q <= wthr;
            if (wr_force)         force_q <= wbit;
            else if (empty_claim) force_q <= 1'b0;
        end
    end
endmodule

// File: rtl/hart_irq_dispatch.sv
module hart_irq_dispatch #(
    parameter int NSRC      = 8,
    parameter int NUM_HARTS = 2,
    parameter int HART_W    = 2,
    parameter int PRIO_W    = 3,
    localparam int HSEL_W   = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
    localparam int AW       = HSEL_W + 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      domain_en,
    input  logic [NSRC:1]             src_pending,
    input  logic [NSRC:1]             src_enable,
    input  logic [3*NSRC-1:0]         src_mode,
    input  logic [NSRC:1]             src_level,
    input  logic [NSRC*HART_W-1:0]    src_hart,
    input  logic [NSRC*PRIO_W-1:0]    src_prio,
    input  logic                      rd_en,
    input  logic [AW-1:0]             rd_addr,
    output logic [31:0]               rd_data,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [31:0]               wr_data,
    output logic [NUM_HARTS-1:0]      hart_irq,
    output logic [NSRC:1]             pend_clr,
    output logic [NSRC:1]             pend_set
);
    import hid_pkg::*;

    logic [HSEL_W-1:0] rd_hsel, wr_hsel;
    logic [4:0]        rd_off, wr_off;
    logic              rd_ok, wr_ok, claim_rd;

    logic                 found     [NUM_HARTS];
    logic [ID_W-1:0]      best_id   [NUM_HARTS];
    logic [PRIO_W-1:0]    best_prio [NUM_HARTS];
    logic [PRIO_W-1:0]    thresh_q  [NUM_HARTS];
    logic [NUM_HARTS-1:0] deliv_vec, force_vec;

    logic                 sel_found;
    logic [ID_W-1:0]      sel_id;
    logic [PRIO_W-1:0]    sel_prio;
    logic [31:0]          top_val;
    logic                 unused_wr;

    assign rd_hsel  = rd_addr[AW-1:5];
    assign rd_off   = rd_addr[4:0];
    assign wr_hsel  = wr_addr[AW-1:5];
    assign wr_off   = wr_addr[4:0];
    assign unused_wr = &{1'b0, wr_data[31:PRIO_W]};

    generate
        if (NUM_HARTS == (1 << HSEL_W)) begin : g_full_sel
            assign rd_ok = 1'b1;
            assign wr_ok = 1'b1;
        end else begin : g_part_sel
            assign rd_ok = (rd_hsel < HSEL_W'(NUM_HARTS));
            assign wr_ok = (wr_hsel < HSEL_W'(NUM_HARTS));
        end
    endgenerate

    assign claim_rd = rd_en && rd_ok && (rd_off == OFF_CLAIM);

    generate
        for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
            logic wsel, rsel;
            assign wsel = wr_en && wr_ok && (wr_hsel == HSEL_W'(h));
            assign rsel = (rd_hsel == HSEL_W'(h));

            hid_select #(
                .NSRC(NSRC), .HART_W(HART_W), .PRIO_W(PRIO_W), .HART(h)
            ) u_sel (
                .pend      (src_pending),
                .en        (src_enable),
                .tgt_hart  (src_hart),
                .tgt_prio  (src_prio),
                .thresh    (thresh_q[h]),
                .found     (found[h]),
                .best_id   (best_id[h]),
                .best_prio (best_prio[h])
            );

            hid_hart_ctl #(.PRIO_W(PRIO_W)) u_ctl (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_deliv    (wsel && (wr_off == OFF_DELIV)),
                .wr_force    (wsel && (wr_off == OFF_FORCE)),
                .wr_thresh   (wsel && (wr_off == OFF_THRESH)),
                .wbit        (wr_data[0]),
                .wthr        (wr_data[PRIO_W-1:0]),
                .empty_claim (claim_rd && rsel && !found[h]),
                .deliv_q     (deliv_vec[h]),
                .force_q     (force_vec[h]),
                .thresh_q    (thresh_q[h])
            );

            assign hart_irq[h] = domain_en && deliv_vec[h] &&
                                 (force_vec[h] || found[h]);
        end
    endgenerate

    assign sel_found = found[rd_hsel];
    assign sel_id    = best_id[rd_hsel];
    assign sel_prio  = best_prio[rd_hsel];
    assign top_val   = sel_found ? {6'd0, sel_id, 8'd0, 8'(sel_prio)} : 32'd0;

    always_comb begin
        rd_data = '0;
        if (rd_en && rd_ok) begin
            case (rd_off)
                OFF_DELIV:          rd_data = {31'd0, deliv_vec[rd_hsel]};
                OFF_FORCE:          rd_data = {31'd0, force_vec[rd_hsel]};
                OFF_THRESH:         rd_data = 32'(thresh_q[rd_hsel]);
                OFF_TOP, OFF_CLAIM: rd_data = top_val;
                default:            rd_data = '0;
            endcase
        end
    end

    always_comb begin
        logic [2:0] m;
        m        = '0;
        pend_clr = '0;
        pend_set = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (claim_rd && sel_found && (sel_id == ID_W'(i))) begin
                pend_clr[i] = 1'b1;
                m = src_mode[(i-1)*3 +: 3];
                if (((m == MODE_LVL_HI) && src_level[i]) ||
                    ((m == MODE_LVL_LO) && !src_level[i]))
                    pend_set[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hart_irq_dispatch_chk.sv
module hart_irq_dispatch_chk #(
    parameter int NSRC      = 8,
    parameter int NUM_HARTS = 2,
    parameter int AW        = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 domain_en,
    input logic                 rd_en,
    input logic [AW-1:0]        rd_addr,
    input logic [31:0]          rd_data,
    input logic                 wr_en,
    input logic [NUM_HARTS-1:0] hart_irq,
    input logic [NSRC:1]        pend_clr,
    input logic [NSRC:1]        pend_set,
    input logic [NUM_HARTS-1:0] force_vec
);
    import hid_pkg::*;

    // R8: at most one source is cleared per claim
    a_r8_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr));

    // R8: clear strobes only come from a claim read
    a_r8_clr_on_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_clr) |-> (rd_en && (rd_addr[4:0] == OFF_CLAIM)));

    // R9: re-pend only targets the source being cleared
    a_r9_set_within_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_set) |-> ((pend_set & ~pend_clr) == '0));

    // R7: the domain enable gates every line
    a_r7_domain_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !domain_en |-> (hart_irq == '0));

    // R10: an empty claim without a concurrent write drops force
    a_r10_empty_claim_force: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr[4:0] == OFF_CLAIM) && (rd_data == 32'd0) && !wr_en &&
         (int'(rd_addr[AW-1:5]) < NUM_HARTS))
        |=> (force_vec[$past(rd_addr[AW-1:5])] == 1'b0));

    // R6: top-interrupt layout
    a_r6_top_format: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ((rd_addr[4:0] == OFF_TOP) || (rd_addr[4:0] == OFF_CLAIM)) &&
         (rd_data != 32'd0))
        |-> ((rd_data[31:26] == 6'd0) && (rd_data[15:8] == 8'd0) &&
             (rd_data[25:16] != 10'd0)));
endmodule

bind hart_irq_dispatch hart_irq_dispatch_chk #(
    .NSRC(NSRC), .NUM_HARTS(NUM_HARTS), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .domain_en (domain_en),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .hart_irq  (hart_irq),
    .pend_clr  (pend_clr),
    .pend_set  (pend_set),
    .force_vec (force_vec)
);

// File: tb/hart_irq_dispatch_tb_top.sv
module hart_irq_dispatch_tb_top;
    localparam int NSRC = 8;
    localparam int NH   = 2;
    localparam int HW   = 2;
    localparam int PW   = 3;
    localparam int AW   = 6;

    localparam logic [4:0] O_DEL = 5'h00, O_FRC = 5'h04, O_THR = 5'h08,
                           O_TOP = 5'h18, O_CLM = 5'h1C;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, domain_en;
    logic [NSRC:1] pend, en, level;
    logic [HW-1:0] b_hart [1:NSRC];
    logic [PW-1:0] b_prio [1:NSRC];
    logic [2:0]    b_mode [1:NSRC];
    logic [3*NSRC-1:0]  f_mode;
    logic [NSRC*HW-1:0] f_hart;
    logic [NSRC*PW-1:0] f_prio;
    logic rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [31:0] wr_data, rd_data;
    logic [NH-1:0] hart_irq;
    logic [NSRC:1] pend_clr, pend_set, cap_clr, cap_set;

    int total = 0, bad = 0;
    bit done = 0;
    int thr_m [NH];
    bit deliv_m [NH];
    logic [31:0] rng = 32'h1234_5678;

    always_comb begin
        for (int i = 1; i <= NSRC; i++) begin
            f_mode[(i-1)*3 +: 3]   = b_mode[i];
            f_hart[(i-1)*HW +: HW] = b_hart[i];
            f_prio[(i-1)*PW +: PW] = b_prio[i];
        end
    end

    hart_irq_dispatch #(.NSRC(NSRC), .NUM_HARTS(NH), .HART_W(HW), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .domain_en(domain_en),
        .src_pending(pend), .src_enable(en), .src_mode(f_mode), .src_level(level),
        .src_hart(f_hart), .src_prio(f_prio),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hart_irq(hart_irq), .pend_clr(pend_clr), .pend_set(pend_set)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic [NSRC:1] oh(input int i);
        return NSRC'(1) << (i - 1);
    endfunction

    function automatic logic [31:0] m_top(input int h, input int thr);
        int bp = 99, bi = 0, p;
        for (int i = 1; i <= NSRC; i++) begin
            p = (b_prio[i] == 0) ? 1 : int'(b_prio[i]);
            if (pend[i] && en[i] && (int'(b_hart[i]) == h) &&
                ((thr == 0) || (p < thr)) && (p < bp)) begin
                bp = p;
                bi = i;
            end
        end
        return (bi == 0) ? 32'd0 : ((32'(bi) << 16) | 32'(bp));
    endfunction

    task automatic access(input bit dr, input int rh, input logic [4:0] ro,
                          input bit dw, input int wh, input logic [4:0] wo,
                          input logic [31:0] wd, output logic [31:0] d);
        @(negedge clk);
        rd_en   = dr;
        rd_addr = AW'(rh * 32 + int'(ro));
        wr_en   = dw;
        wr_addr = AW'(wh * 32 + int'(wo));
        wr_data = wd;
        #1;
        d       = rd_data;
        cap_clr = pend_clr;
        cap_set = pend_set;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        wr_en = 1'b0;
        pend  = (pend & ~cap_clr) | cap_set;
    endtask

    task automatic rd(input int h, input logic [4:0] o, output logic [31:0] d);
        access(1'b1, h, o, 1'b0, 0, 5'h0, 32'd0, d);
    endtask

    task automatic wr(input int h, input logic [4:0] o, input logic [31:0] v);
        logic [31:0] d;
        access(1'b0, 0, 5'h0, 1'b1, h, o, v, d);
        if (o == O_THR) thr_m[h] = int'(v[PW-1:0]);
        if (o == O_DEL) deliv_m[h] = v[0];
    endtask

    task automatic clear_src();
        pend = '0; en = '0; level = '0;
        for (int i = 1; i <= NSRC; i++) begin
            b_hart[i] = '0; b_prio[i] = 3'd1; b_mode[i] = 3'd4;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        rst_n = 1'b0; domain_en = 1'b1;
        rd_en = 0; wr_en = 0; rd_addr = '0; wr_addr = '0; wr_data = '0;
        cap_clr = '0; cap_set = '0;
        clear_src();
        for (int h = 0; h < NH; h++) begin thr_m[h] = 0; deliv_m[h] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1 chk(hart_irq == '0, "R1 irq", 32'(hart_irq), 0);
        rd(0, O_DEL, d); chk(d == 0, "R1 deliv", d, 0);
        rd(1, O_FRC, d); chk(d == 0, "R1 force", d, 0);
        rd(1, O_THR, d); chk(d == 0, "R1 thresh", d, 0);
        rd(0, O_TOP, d); chk(d == 0, "R1 top", d, 0);

        // R2 field widths and offsets
        wr(0, O_DEL, 32'hFFFF_FFFF); rd(0, O_DEL, d); chk(d == 1, "R2 deliv bit", d, 1);
        wr(0, O_FRC, 32'hFFFF_FFFE); rd(0, O_FRC, d); chk(d == 0, "R2 force bit0", d, 0);
        wr(1, O_THR, 32'h0000_00FF); rd(1, O_THR, d); chk(d == 7, "R2 thresh mask", d, 7);
        wr(1, O_THR, 32'd0);
        wr(0, O_TOP, 32'hFFFF_FFFF); wr(0, O_CLM, 32'hFFFF_FFFF);
        rd(0, O_THR, d); chk(d == 0, "R2 top/claim write ignored", d, 0);
        rd(0, O_FRC, d); chk(d == 0, "R2 top/claim write ignored force", d, 0);
        rd(0, 5'h0C, d); chk(d == 0, "R2 unmapped read", d, 0);
        wr(1, O_DEL, 32'd1);

        // R4 zero priority ranked as 1, tie to lower number
        clear_src();
        pend[2] = 1; en[2] = 1; b_prio[2] = 3'd1;
        pend[3] = 1; en[3] = 1; b_prio[3] = 3'd0;
        rd(0, O_TOP, d); e = (32'd2 << 16) | 32'd1; chk(d == e, "R4 tie", d, e);
        pend[2] = 0;
        rd(0, O_TOP, d); e = (32'd3 << 16) | 32'd1; chk(d == e, "R4 zero prio", d, e);

        // R3 R5 R6 R7 R8 sweep against the model
        for (int it = 0; it < 300; it++) begin
            logic [31:0] r;
            r = nxt(); pend = r[7:0]; en = r[15:8];
            domain_en = (r[23:16] != 8'h00);
            for (int i = 1; i <= NSRC; i++) begin
                r = nxt();
                b_hart[i] = r[1:0]; b_prio[i] = r[4:2];
            end
            r = nxt();
            wr(0, O_THR, {29'd0, r[2:0]});
            wr(1, O_THR, {29'd0, r[5:3]});
            for (int h = 0; h < NH; h++) begin
                rd(h, O_TOP, d);
                e = m_top(h, thr_m[h]);
                chk(d == e, "R3/R5/R6 top value", d, e);
                chk(cap_clr == '0 && cap_set == '0, "R8 top read no side effect",
                    32'(cap_clr), 0);
                chk(hart_irq[h] == (domain_en && deliv_m[h] && (e != 0)), "R7 irq line",
                    32'(hart_irq[h]), 32'(domain_en && deliv_m[h] && (e != 0)));
            end
        end
        domain_en = 1'b1;
        wr(0, O_THR, 32'd0); wr(1, O_THR, 32'd0);

        // R7 directed gating
        clear_src();
        pend[4] = 1; en[4] = 1;
        #1 chk(hart_irq[0] == 1, "R7 on", 32'(hart_irq[0]), 1);
        domain_en = 0;
        #1 chk(hart_irq[0] == 0, "R7 domain off", 32'(hart_irq[0]), 0);
        domain_en = 1;
        wr(0, O_DEL, 32'd0);
        chk(hart_irq[0] == 0, "R7 deliv off", 32'(hart_irq[0]), 0);
        wr(0, O_DEL, 32'd1);

        // R8 R9 claims across modes
        clear_src();
        pend[5] = 1; en[5] = 1; b_hart[5] = 2'd1; b_prio[5] = 3'd4;
        b_mode[5] = 3'd6; level[5] = 1;
        rd(1, O_CLM, d); e = (32'd5 << 16) | 32'd4;
        chk(d == e, "R8 claim value", d, e);
        chk(cap_clr == oh(5), "R8 claim clr", 32'(cap_clr), 32'(oh(5)));
        chk(cap_set == oh(5), "R9 level-high re-pend", 32'(cap_set), 32'(oh(5)));
        @(negedge clk); #1 chk(pend_clr == '0, "R8 single pulse", 32'(pend_clr), 0);
        b_mode[5] = 3'd7; level[5] = 0;
        rd(1, O_CLM, d); chk(cap_set == oh(5), "R9 level-low re-pend", 32'(cap_set), 32'(oh(5)));
        level[5] = 1;
        rd(1, O_CLM, d); chk(cap_set == '0, "R9 level-low inactive", 32'(cap_set), 0);
        rd(1, O_TOP, d); chk(d == 0, "R9 cleared after claim", d, 0);
        pend[5] = 1; b_mode[5] = 3'd4;
        rd(1, O_CLM, d); chk(cap_clr == oh(5) && cap_set == '0, "R9 edge no re-pend",
                             32'(cap_set), 0);
        pend[5] = 1; b_mode[5] = 3'd6; level[5] = 0;
        rd(1, O_CLM, d); chk(cap_set == '0, "R9 level-high inactive", 32'(cap_set), 0);

        // R10 empty claim and force
        clear_src();
        wr(0, O_FRC, 32'd1);
        chk(hart_irq[0] == 1, "R10 force drives line", 32'(hart_irq[0]), 1);
        rd(0, O_CLM, d); chk(d == 0, "R10 empty claim value", d, 0);
        chk(hart_irq[0] == 0, "R10 line drops", 32'(hart_irq[0]), 0);
        rd(0, O_FRC, d); chk(d == 0, "R10 force cleared", d, 0);
        access(1'b1, 0, O_CLM, 1'b1, 0, O_FRC, 32'd1, d);
        rd(0, O_FRC, d); chk(d == 1, "R10 write wins", d, 1);
        wr(0, O_FRC, 32'd0);

        // R11 claim with concurrent threshold write
        clear_src();
        pend[6] = 1; en[6] = 1; b_prio[6] = 3'd5; level[6] = 1; b_mode[6] = 3'd6;
        access(1'b1, 0, O_CLM, 1'b1, 0, O_THR, 32'd3, d);
        thr_m[0] = 3;
        e = (32'd6 << 16) | 32'd5;
        chk(d == e, "R11 old threshold used", d, e);
        chk(cap_clr == oh(6), "R11 clr", 32'(cap_clr), 32'(oh(6)));
        rd(0, O_THR, d); chk(d == 3, "R11 new threshold stored", d, 3);
        rd(0, O_TOP, d); chk(d == 0, "R11 new threshold filters", d, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule